// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block steps a processor core into one of three low-power states: doze, nap or sleep. The states are layered. Doze halts the core. Nap first halts the core and then stops it. Sleep does everything nap does, and it also asks every other device interface to stop. Only when all enabled interfaces have answered does sleep gate off the main clocks and report the device as asleep. The interrupt controller clock stays on in every state.

A request can come from two places. The first is the core's own doze, nap and sleep control bits, which count only while the core's wait-enable qualifier is high. The second is a two-bit request register, which any bus master, including the core, can write. That register has a doze bit and a sleep bit only, so nap can be started only by the core. The register contents and the current sequencer state can be read back. A wake input sends the sequencer back to idle from any state.

Top module: `lp_entry_seq`

## Requirements
- R1: After reset the state output `mode` is 0 (idle), `halt_req`, `stop_req`, `if_stop_req` and `asleep` are low, `ready` and `clk_en_main` are high, and both register request bits read 0.
- R2: The core bits `core_doze`, `core_nap` and `core_sleep` are ignored unless `core_wait_en` is high.
- R3: Doze entry raises `halt_req` one cycle after the request. When `halted_ack` is seen, `mode` moves to 4 (dozed). While the block waits for `halted_ack`, `mode` reads 1.
- R4: Nap entry completes the doze handshake first. It then holds `halt_req` and raises `stop_req`, with `mode` reading 2. When `stopped_ack` is seen, `mode` moves to 5 (napped). `stop_req` never rises before `halted_ack` has been seen.
- R5: Sleep entry completes the doze handshake and then raises `stop_req` and `if_stop_req` together. `if_stop_req` equals the interface mask (default 4'b1011). After `stopped_ack`, `mode` reads 3 while the block waits on the interface acknowledges.
- R6: From `mode` 3 the block advances to 6 (asleep) only when every interface selected by the mask has its bit of `if_stop_ack` high. Bits outside the mask are ignored.
- R7: In `mode` 6, `asleep` is high, and `ready` and `clk_en_main` are low. In every other state, `asleep` is low and `ready` and `clk_en_main` are high.
- R8: A cycle with `csr_wr` high loads `csr_doze_wdata` and `csr_sleep_wdata` into the request register, but only in idle. The register bits read back on `csr_doze` and `csr_sleep`, and a set bit starts doze or sleep entry on the following cycle.
- R9: When requests arrive together, the deepest one wins (sleep over nap over doze).
- R10: While `mode` is not 0, new requests and register writes have no effect.
- R11: `wake` returns `mode` to 0 on the next cycle, drops `halt_req`, `stop_req` and `if_stop_req`, raises `ready` and `clk_en_main`, and clears both register request bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_wait_en | input | 1 | Core wait-enable qualifier for the core bits |
| core_doze | input | 1 | Core doze request bit |
| core_nap | input | 1 | Core nap request bit |
| core_sleep | input | 1 | Core sleep request bit |
| csr_wr | input | 1 | Write strobe for the request register |
| csr_doze_wdata | input | 1 | Write data, doze request bit |
| csr_sleep_wdata | input | 1 | Write data, sleep request bit |
| csr_doze | output | 1 | Readback, doze request bit |
| csr_sleep | output | 1 | Readback, sleep request bit |
| mode | output | 3 | Current state: 0 idle, 1 halt wait, 2 stop wait, 3 interface wait, 4 dozed, 5 napped, 6 asleep |
| halt_req | output | 1 | Halt request to the core |
| halted_ack | input | 1 | Core halted acknowledge |
| stop_req | output | 1 | Stop request to the core |
| stopped_ack | input | 1 | Core stopped acknowledge |
| if_stop_req | output | NUM_IF | Stop requests to the other interfaces |
| if_stop_ack | input | NUM_IF | Stop acknowledges from the other interfaces |
| wake | input | 1 | Return to idle |
| asleep | output | 1 | Sleep entry complete |
| ready | output | 1 | Device ready status |
| clk_en_main | output | 1 | Enable for every clock except the interrupt controller clock |

## Verification
The assertions are checked on every cycle and cover the fixed relations between signals. Stop is never requested without halt. `stop_req` cannot rise before a halted acknowledge, and the asleep state cannot be entered before all masked interfaces have acknowledged. The `asleep`, `ready` and clock-enable outputs stay consistent with each other. A wake always lands in idle, and a settled state holds against new requests. Some behaviours can only be shown by the bench's scenarios: which target is picked when requests collide, that the core bits are ignored without the qualifier, that register writes are dropped while busy, and that wake clears the register so that idle stays idle afterwards.

// File: rtl/lp_entry_seq.sv
module lp_entry_seq #(
  parameter int unsigned NUM_IF = 4,
  parameter logic [NUM_IF-1:0] IF_MASK = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_wait_en,
  input  logic              core_doze,
  input  logic              core_nap,
  input  logic              core_sleep,
  input  logic              csr_wr,
  input  logic              csr_doze_wdata,
  input  logic              csr_sleep_wdata,
  output logic              csr_doze,
  output logic              csr_sleep,
  output logic [2:0]        mode,
  output logic              halt_req,
  input  logic              halted_ack,
  output logic              stop_req,
  input  logic              stopped_ack,
  output logic [NUM_IF-1:0] if_stop_req,
  input  logic [NUM_IF-1:0] if_stop_ack,
  input  logic              wake,
  output logic              asleep,
  output logic              ready,
  output logic              clk_en_main
);
  localparam logic [2:0] S_IDLE = 3'd0, S_HWAIT = 3'd1, S_SWAIT = 3'd2,
                         S_IFWAIT = 3'd3, S_DOZED = 3'd4, S_NAPPED = 3'd5,
                         S_ASLEEP = 3'd6;
  localparam logic [1:0] T_DOZE = 2'd1, T_NAP = 2'd2, T_SLEEP = 2'd3;

  logic [2:0] state, state_n;
  logic [1:0] target, target_n;
  logic       want_doze, want_nap, want_sleep, if_all_ack;

  assign want_sleep = (core_wait_en & core_sleep) | csr_sleep;
  assign want_nap   = core_wait_en & core_nap;
  assign want_doze  = (core_wait_en & core_doze) | csr_doze;
  assign if_all_ack = &(if_stop_ack | ~IF_MASK);

  always_comb begin
    state_n  = state;
    target_n = target;
    unique case (state)
      S_IDLE: begin
        if (want_sleep) begin
          state_n = S_HWAIT; target_n = T_SLEEP;
        end else if (want_nap) begin
          state_n = S_HWAIT; target_n = T_NAP;
        end else if (want_doze) begin
          state_n = S_HWAIT; target_n = T_DOZE;
        end
      end
      S_HWAIT:  if (halted_ack) state_n = (target == T_DOZE) ? S_DOZED : S_SWAIT;
      S_SWAIT:  if (stopped_ack) state_n = (target == T_NAP) ? S_NAPPED : S_IFWAIT;
      S_IFWAIT: if (if_all_ack) state_n = S_ASLEEP;
      default:  ;
    endcase
    if (wake) begin
      state_n  = S_IDLE;
      target_n = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      target    <= 2'd0;
      csr_doze  <= 1'b0;
      csr_sleep <= 1'b0;
    end else begin
      state  <= state_n;
      target <= target_n;
      if (wake) begin
        csr_doze  <= 1'b0;
        csr_sleep <= 1'b0;
      end else if (csr_wr && state == S_IDLE) begin
        csr_doze  <= csr_doze_wdata;
        csr_sleep <= csr_sleep_wdata;
      end
    end
  end

  assign mode        = state;
  assign halt_req    = state != S_IDLE;
  assign stop_req    = state inside {S_SWAIT, S_IFWAIT, S_NAPPED, S_ASLEEP};
  assign if_stop_req = (target == T_SLEEP && state inside {S_SWAIT, S_IFWAIT, S_ASLEEP})
                       ? IF_MASK : '0;
  assign asleep      = state == S_ASLEEP;
  assign ready       = ~asleep;
  assign clk_en_main = ~asleep;
endmodule

// File: rtl/lp_entry_seq_chk.sv
module lp_entry_seq_chk #(
  parameter int unsigned NUM_IF = 4,
  parameter logic [NUM_IF-1:0] IF_MASK = 4'b1011
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              halt_req,
  input logic              halted_ack,
  input logic              stop_req,
  input logic [NUM_IF-1:0] if_stop_req,
  input logic [NUM_IF-1:0] if_stop_ack,
  input logic              wake,
  input logic              asleep,
  input logic              ready,
  input logic              clk_en_main
);
  AST_STOP_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n) stop_req |-> halt_req); // R4
  AST_STOP_AFTER_HALTED: assert property (@(posedge clk) disable iff (!rst_n) $rose(stop_req) |-> $past(halted_ack)); // R4
  AST_IFREQ_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n) (if_stop_req != '0) |-> stop_req && if_stop_req == IF_MASK); // R5
  AST_ASLEEP_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n) $rose(asleep) |-> $past(&(if_stop_ack | ~IF_MASK))); // R6
  AST_ASLEEP_STATUS: assert property (@(posedge clk) disable iff (!rst_n) asleep == (mode == 3'd6) && ready == !asleep && clk_en_main == !asleep); // R7
  AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (mode inside {3'd4, 3'd5, 3'd6}) && !wake |=> $stable(mode)); // R10
  AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) wake |=> mode == 3'd0 && !halt_req && !stop_req && ready); // R11
endmodule

bind lp_entry_seq lp_entry_seq_chk #(.NUM_IF(NUM_IF), .IF_MASK(IF_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .halt_req(halt_req), .halted_ack(halted_ack),
  .stop_req(stop_req), .if_stop_req(if_stop_req), .if_stop_ack(if_stop_ack), .wake(wake),
  .asleep(asleep), .ready(ready), .clk_en_main(clk_en_main));

// File: tb/lp_entry_seq_bench.sv
module lp_entry_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_en = 0, cd = 0, cn = 0, cs = 0, wr = 0, wd = 0, ws = 0;
  logic halted = 0, stopped = 0, wk = 0;
  logic [3:0] ifack = '0;
  logic csr_d, csr_s, halt, stop, aslp, rdy, cken;
  logic [2:0] md;
  logic [3:0] ifreq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  lp_entry_seq u_lp_entry_seq (
    .clk(clk), .rst_n(rst_n), .core_wait_en(wait_en), .core_doze(cd), .core_nap(cn),
    .core_sleep(cs), .csr_wr(wr), .csr_doze_wdata(wd), .csr_sleep_wdata(ws),
    .csr_doze(csr_d), .csr_sleep(csr_s), .mode(md), .halt_req(halt), .halted_ack(halted),
    .stop_req(stop), .stopped_ack(stopped), .if_stop_req(ifreq), .if_stop_ack(ifack),
    .wake(wk), .asleep(aslp), .ready(rdy), .clk_en_main(cken));

  // {wake,wait_en,cd,cn,cs,wr,wd,ws,halted,stopped,ifack[3:0]} , {mode[2:0],halt,stop,ifreq_any,asleep,ready}
  localparam logic [21:0] VEC [18] = '{
    {14'b00000000000000, 8'b00000001},  // R1 idle
    {14'b00100000000000, 8'b00000001},  // R2 no qualifier
    {14'b01100000000000, 8'b00110001},  // R3 doze start
    {14'b00000000000000, 8'b00110001},  // R3 wait halted
    {14'b00000000100000, 8'b10010001},  // R3 dozed
    {14'b01001000100000, 8'b10010001},  // R10 ignored
    {14'b10000000100000, 8'b00000001},  // R11 wake
    {14'b01110000000000, 8'b00110001},  // R9 nap over doze
    {14'b00000000100000, 8'b01011001},  // R4 stop wait
    {14'b00000000110000, 8'b10111001},  // R4 napped
    {14'b10000000000000, 8'b00000001},  // R11
    {14'b00000101000000, 8'b00000001},  // R8 write sleep
    {14'b00000000000000, 8'b00110001},  // R8 start next cycle
    {14'b00000000100000, 8'b01011101},  // R5 if stop
    {14'b00000000110011, 8'b01111101},  // R5 if wait
    {14'b00000000111011, 8'b11011110},  // R6 R7 asleep
    {14'b10000000000000, 8'b00000001},  // R11
    {14'b00000000000000, 8'b00000001}   // R11 register cleared
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [13:0] v);
    @(negedge clk);
    {wk, wait_en, cd, cn, cs, wr, wd, ws, halted, stopped, ifack} = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset", {md, halt, stop, |ifreq, aslp, rdy, cken, csr_d, csr_s}, {3'd0, 8'b00001100});
    rst_n = 1'b1;
    for (int i = 0; i < 18; i++) begin
      drive(VEC[i][21:8]);
      chk($sformatf("vec%0d", i), {md, halt, stop, |ifreq, aslp, rdy}, VEC[i][7:0]);
    end
    // R8 register doze path, readback, R10 write ignored while busy
    drive(14'b00000110000000);
    chk("R8 readback", {csr_d, csr_s}, 2'b10);
    drive(14'b00000000000000);
    chk("R8 doze start", md, 3'd1);
    drive(14'b00000000100000);
    chk("R8 dozed", md, 3'd4);
    drive(14'b00000101100000);
    chk("R10 write ignored", {csr_d, csr_s, md}, {2'b10, 3'd4});
    drive(14'b10000000000000);
    chk("R11 cleared", {csr_d, csr_s, md, cken}, {2'b00, 3'd0, 1'b1});
    // R9 sleep over doze, R5 mask value, R6 mask gating
    drive(14'b01101000000000);
    chk("R9 start", md, 3'd1);
    drive(14'b00000000100000);
    chk("R5 if_stop_req mask", ifreq, 4'b1011);
    drive(14'b00000000110100);
    chk("R5 if wait", md, 3'd3);
    drive(14'b00000000110100);
    chk("R6 unmasked ack only", md, 3'd3);
    drive(14'b00000000111010);
    chk("R6 bit0 missing", md, 3'd3);
    drive(14'b00000000111011);
    chk("R7 asleep", {md, aslp, rdy, cken}, {3'd6, 3'b100});
    drive(14'b10000000000000);
    chk("R11 wake from sleep", {md, halt, stop, ifreq, rdy, cken}, {3'd0, 2'b00, 4'b0000, 2'b11});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule